// File: doc/BRIEF.md
# Shared Instruction/Data Memory Port Stall Controller

This block is a cycle-accurate timing model of a five-stage in-order pipeline (fetch, decode, execute, memory, write-back) in which instruction fetch and data access go through one single-port memory. The memory can perform only one access per clock. A source offers instruction-class tokens on a valid/ready handshake. Accepting a token is the fetch, and it uses the memory port in that same cycle. Accepted tokens then move one stage per clock through four stage registers: decode, execute, memory and write-back.

A load or store sitting in the memory stage needs the port for its data access. That data access always wins, so the fetch offered in the same cycle is refused. The refused fetch is the one three positions behind the memory operation. On every refusal a bubble enters decode while the older tokens keep moving. The block reports stage occupancy and token class, which user owns the port in the current cycle, a free-running cycle counter, and a counter of refused fetch cycles. Decoding, register file and arithmetic are not modelled.

Top module: `ump_stall_ctrl`

## Requirements
- R1: While reset is high at a clock edge, all four stage valid bits clear and both counters become zero.
- R2: A token accepted in a cycle (in_valid and in_ready both high) appears in decode (stg_valid bit 0) after the next edge, with the same class. Class codes are 0 register op, 1 load, 2 store, 3 branch. It then advances one stage per edge through execute (bit 1), memory (bit 2) and write-back (bit 3). Stage i carries its class on stg_class[2i+1:2i]. Tokens leave write-back in acceptance order.
- R3: Whenever the memory stage holds a valid load or store, in_ready is low and port_owner is 2 (data), whether or not a fetch is offered.
- R4: Whenever the memory stage holds no load or store, in_ready is high. In that case port_owner is 1 (fetch) if in_valid is high, and 0 (idle) otherwise.
- R5: In a cycle where a fetch is offered but refused, the token is not consumed, and decode holds a bubble (valid 0) after the next edge.
- R6: stall_cnt rises by exactly one after each cycle in which in_valid is high and in_ready is low. In every other cycle it keeps its value.
- R7: cycle_cnt rises by one at every edge with reset low.
- R8: Register-op and branch tokens in the memory stage never block a fetch, so a stream made only of them is accepted one token per cycle with no stall.
- R9: A back-to-back stream made only of loads is accepted at one token per two cycles on average. Six loads offered from an empty pipeline are accepted over nine edges, with three refused cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A token is offered for fetch |
| in_class | input | 2 | Class of the offered token (0 reg op, 1 load, 2 store, 3 branch) |
| in_ready | output | 1 | The memory port is free for a fetch this cycle |
| stg_valid | output | 4 | Occupancy of decode, execute, memory, write-back (bits 0..3) |
| stg_class | output | 8 | Class of each stage, two bits per stage |
| port_owner | output | 2 | Port user this cycle: 0 idle, 1 fetch, 2 data |
| cycle_cnt | output | CNT_W | Cycles since reset |
| stall_cnt | output | CNT_W | Cycles with a refused fetch |

## Verification
The checker tests the cycle-local rules on every edge. These are: the data access wins whenever the memory stage holds a load or store, register ops and branches never block, an accepted token lands in decode, a refusal injects a bubble, each stage copies the one before it, and both counters step exactly as specified. Throughput cannot be seen from one cycle: only the bench scenarios can show that a pure load stream settles at two cycles per token and that a mixed store sequence loses exactly one slot. The same holds for order across the whole pipe and for the reset values, which the bench establishes with its scoreboard and timed counter reads.

// File: rtl/ump_pkg.sv
package ump_pkg;

  typedef enum logic [1:0] {
    CLS_REG    = 2'd0,
    CLS_LOAD   = 2'd1,
    CLS_STORE  = 2'd2,
    CLS_BRANCH = 2'd3
  } op_class_e;

  typedef enum logic [1:0] {
    OWN_IDLE  = 2'd0,
    OWN_FETCH = 2'd1,
    OWN_DATA  = 2'd2
  } port_user_e;

  typedef struct packed {
    logic      vld;
    op_class_e cls;
  } slot_t;

  function automatic logic needs_data_port(input slot_t s);
    return s.vld && (s.cls == CLS_LOAD || s.cls == CLS_STORE);
  endfunction

endpackage

// File: rtl/ump_port_arbiter.sv
module ump_port_arbiter
  import ump_pkg::*;
(
  input  logic       fetch_req,
  input  slot_t      mem_slot,
  output logic       fetch_grant,
  output port_user_e owner
);

  logic data_req;

  always_comb begin
    data_req    = needs_data_port(mem_slot);
    fetch_grant = fetch_req && !data_req;
    if (data_req)       owner = OWN_DATA;
    else if (fetch_req) owner = OWN_FETCH;
    else                owner = OWN_IDLE;
  end

endmodule

// File: rtl/ump_stage_chain.sv
module ump_stage_chain
  import ump_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  slot_t                  head,
  output slot_t [DEPTH-1:0]      stg
);

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_stage
      slot_t nxt;
      if (g == 0) begin : g_first
        assign nxt = head;
      end else begin : g_rest
        assign nxt = stg[g-1];
      end
      always_ff @(posedge clk) begin
        if (rst) begin
          stg[g].vld <= 1'b0;
          stg[g].cls <= CLS_REG;
        end else begin
          stg[g] <= nxt;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/ump_event_counters.sv
module ump_event_counters #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stall_evt,
  output logic [CNT_W-1:0] cycle_cnt,
  output logic [CNT_W-1:0] stall_cnt
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cycle_cnt <= '0;
      stall_cnt <= '0;
    end else begin
      cycle_cnt <= cycle_cnt + ONE;
      if (stall_evt) stall_cnt <= stall_cnt + ONE;
    end
  end

endmodule

// File: rtl/ump_stall_ctrl.sv
module ump_stall_ctrl
  import ump_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       in_class,
  output logic             in_ready,
  output logic [3:0]       stg_valid,
  output logic [7:0]       stg_class,
  output logic [1:0]       port_owner,
  output logic [CNT_W-1:0] cycle_cnt,
  output logic [CNT_W-1:0] stall_cnt
);

  localparam int NSTAGE  = 5;
  localparam int DEPTH   = NSTAGE - 1;
  localparam int MEM_POS = 2;

  slot_t [DEPTH-1:0] stg;
  slot_t             head;
  logic              grant;
  port_user_e        owner;

  ump_port_arbiter u_arb (
    .fetch_req   (in_valid),
    .mem_slot    (stg[MEM_POS]),
    .fetch_grant (grant),
    .owner       (owner)
  );

  always_comb begin
    head.vld = grant;
    head.cls = grant ? op_class_e'(in_class) : CLS_REG;
  end

  ump_stage_chain #(.DEPTH(DEPTH)) u_chain (
    .clk  (clk),
    .rst  (rst),
    .head (head),
    .stg  (stg)
  );

  ump_event_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .stall_evt (in_valid && !grant),
    .cycle_cnt (cycle_cnt),
    .stall_cnt (stall_cnt)
  );

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_out
      assign stg_valid[g]         = stg[g].vld;
      assign stg_class[2*g +: 2]  = stg[g].cls;
    end
  endgenerate

  assign in_ready   = grant || !in_valid ? !needs_data_port(stg[MEM_POS]) : 1'b0;
  assign port_owner = owner;

endmodule

// File: rtl/ump_stall_chk.sv
module ump_stall_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [1:0]       in_class,
  input logic             in_ready,
  input logic [3:0]       stg_valid,
  input logic [7:0]       stg_class,
  input logic [1:0]       port_owner,
  input logic [CNT_W-1:0] cycle_cnt,
  input logic [CNT_W-1:0] stall_cnt
);

  logic mem_is_data;
  assign mem_is_data = stg_valid[2] && (stg_class[5:4] == 2'd1 || stg_class[5:4] == 2'd2);

  // R3
  data_wins_chk: assert property (@(posedge clk) disable iff (rst)
    mem_is_data |-> (!in_ready && port_owner == 2'd2));

  // R8
  nonmem_free_chk: assert property (@(posedge clk) disable iff (rst)
    (stg_valid[2] && (stg_class[5:4] == 2'd0 || stg_class[5:4] == 2'd3)) |-> in_ready);

  // R4
  fetch_owner_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_is_data && in_valid) |-> (in_ready && port_owner == 2'd1));

  // R2
  accept_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (stg_valid[0] && stg_class[1:0] == $past(in_class)));

  // R2
  advance_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (stg_valid[3:1] == $past(stg_valid[2:0]) && stg_class[7:2] == $past(stg_class[5:0])));

  // R5
  bubble_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready) |=> !stg_valid[0]);

  // R6
  stall_step_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready) |=> stall_cnt == $past(stall_cnt) + CNT_W'(1));

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && !in_ready) |=> $stable(stall_cnt));

  // R7
  cycle_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cycle_cnt == $past(cycle_cnt) + CNT_W'(1));

endmodule

bind ump_stall_ctrl ump_stall_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/test_ump_stall_ctrl.sv
module test_ump_stall_ctrl;

  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic [1:0]       in_class = 2'd0;
  logic             in_ready;
  logic [3:0]       stg_valid;
  logic [7:0]       stg_class;
  logic [1:0]       port_owner;
  logic [CNT_W-1:0] cycle_cnt;
  logic [CNT_W-1:0] stall_cnt;

  int checks = 0;
  int errors = 0;
  int exp_q[$];

  always #4 clk = ~clk;

  ump_stall_ctrl #(.CNT_W(CNT_W)) i_ump_stall_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_class(in_class),
    .in_ready(in_ready), .stg_valid(stg_valid), .stg_class(stg_class),
    .port_owner(port_owner), .cycle_cnt(cycle_cnt), .stall_cnt(stall_cnt)
  );

  task automatic chk(input logic ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard as tokens reach write-back (R2 order).
  always @(negedge clk) begin
    if (!rst && stg_valid[3]) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected token in write-back", int'(stg_class[7:6]), -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk(int'(stg_class[7:6]) == e, "R2 write-back class/order", int'(stg_class[7:6]), e);
      end
    end
  end

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Driver: offers one token, pushes it on acceptance, returns at a negedge.
  task automatic offer(input logic [1:0] c, output int denied);
    logic [CNT_W-1:0] s0;
    denied = 0;
    in_valid = 1'b1;
    in_class = c;
    forever begin
      #1;
      if (in_ready) begin
        chk(port_owner == 2'd1, "R4 fetch owns port", int'(port_owner), 1);
        exp_q.push_back(int'(c));
        @(posedge clk);
        @(negedge clk);
        chk(stg_valid[0] && stg_class[1:0] == c, "R2 token in decode",
            int'({stg_valid[0], stg_class[1:0]}), int'({1'b1, c}));
        break;
      end else begin
        s0 = stall_cnt;
        chk(port_owner == 2'd2, "R3 data owns port on refusal", int'(port_owner), 2);
        denied++;
        @(posedge clk);
        @(negedge clk);
        chk(!stg_valid[0], "R5 bubble in decode", int'(stg_valid[0]), 0);
        chk(stall_cnt == s0 + CNT_W'(1), "R6 stall step", int'(stall_cnt), int'(s0) + 1);
      end
    end
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int d;
    int tot;
    logic [CNT_W-1:0] c0;
    logic [CNT_W-1:0] s0;

    repeat (3) @(negedge clk);
    chk(stg_valid == 4'd0, "R1 stages clear", int'(stg_valid), 0);
    chk(cycle_cnt == 0 && stall_cnt == 0, "R1 counters zero",
        int'(cycle_cnt) + int'(stall_cnt), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(cycle_cnt == 3, "R7 cycle count", int'(cycle_cnt), 3);
    #1;
    chk(port_owner == 2'd0 && in_ready, "R4 idle port", int'(port_owner), 0);

    // R8: register ops and branches flow one per cycle
    tot = 0;
    offer(2'd0, d); tot += d;
    offer(2'd3, d); tot += d;
    offer(2'd0, d); tot += d;
    offer(2'd3, d); tot += d;
    offer(2'd0, d); tot += d;
    offer(2'd0, d); tot += d;
    chk(tot == 0, "R8 no refusals", tot, 0);
    chk(stall_cnt == 0, "R8 stall count", int'(stall_cnt), 0);
    idle(5);

    // R9: six loads back to back
    c0 = cycle_cnt;
    s0 = stall_cnt;
    tot = 0;
    for (int i = 0; i < 6; i++) begin
      offer(2'd1, d);
      tot += d;
    end
    chk(tot == 3, "R9 refused cycles", tot, 3);
    chk(stall_cnt - s0 == 3, "R9 stall delta", int'(stall_cnt - s0), 3);
    chk(cycle_cnt - c0 == 9, "R9 elapsed edges", int'(cycle_cnt - c0), 9);
    idle(5);

    // Store then register ops: exactly the fourth fetch is refused (R3, R5)
    tot = 0;
    offer(2'd2, d); tot += d;
    offer(2'd0, d); tot += d;
    offer(2'd0, d); tot += d;
    offer(2'd0, d);
    chk(d == 1, "R3 fetch behind store refused once", d, 1);
    chk(tot == 0, "R8 earlier fetches free", tot, 0);
    idle(5);

    // Load in memory stage with no fetch offered (R3, R6)
    offer(2'd1, d);
    s0 = stall_cnt;
    @(negedge clk);
    @(negedge clk);
    #1;
    chk(port_owner == 2'd2 && !in_ready, "R3 data owns port without fetch",
        int'(port_owner), 2);
    idle(4);
    chk(stall_cnt == s0, "R6 no stall without request", int'(stall_cnt), int'(s0));

    idle(4);
    chk(exp_q.size() == 0, "R2 all tokens retired", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule